// File: doc/BRIEF.md
# Two-Agent Hardware Lock Bank

This block is a bank of hardware locks shared by two agents on one chip: a host driver and an embedded management firmware. Each agent has its own simple register port with a write strobe, a read strobe, an address and 32-bit data. To take a lock, an agent writes its own agent bit into that lock's request register. It then polls the lock's grant register until the grant reads back exactly its own bit. Writing the agent bit into the grant register gives the lock back. The same write withdraws the request if the lock has not been granted yet.

Every lock keeps one pending bit per agent and one owner field. When a lock is free, a small arbiter settles pending requests on the next clock edge. The firmware has fixed priority over the host. The winner's pending bit is cleared as the lock is handed over. By convention the host guards the shared event and status memory with lock 4. The host gives up after polling for about 1 ms (100 reads, 10 µs apart) and treats the lock as busy. The hardware itself enforces no timeout.

Top module: `hw_sema_bank`

## Requirements
- R1: After reset, every request register and every grant register reads 0 from both ports.
- R2: Lock n (n = 0 to 7) has its request register at byte address 0x2C + 4·n and its grant register at 0x4C + 4·n. Any other address reads 0, and writes to it change nothing.
- R3: The host's agent bit is bit 12 (0x00001000) and the firmware's is bit 0 (0x00000001). A write acts only when the writing agent's own bit is set in the data. It never acts for the other agent, and all other data bits are ignored.
- R4: A request write sets the writer's pending bit. The request register reads the OR of the agent bits of all pending requesters.
- R5: A lock that is free with at least one request pending is granted at the next clock edge. The grant register then reads only the winner's agent bit, and the winner's pending bit is cleared.
- R6: When both agents are pending on a free lock, the firmware wins and the host stays pending.
- R7: A granted lock stays with its holder until the holder writes its bit to the grant register. The grant then reads 0, and any request still pending is granted one clock later.
- R8: A grant-register write by an agent that is pending but not holding withdraws that agent's request and leaves the owner unchanged.
- R9: A grant-register write by an agent that neither holds nor requests the lock has no effect.
- R10: A request write by the agent that already holds the lock is ignored, so releasing the lock does not grant it back to the same agent.
- R11: Each lock's state changes only through accesses to that lock's own two registers.
- R12: Read data is registered. It appears one clock after the read strobe and shows the state from before that clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr_i | input | 1 | Host write strobe |
| host_rd_i | input | 1 | Host read strobe |
| host_addr_i | input | 16 | Host byte address |
| host_wdata_i | input | 32 | Host write data |
| host_rdata_o | output | 32 | Host read data, one cycle after the strobe |
| fw_wr_i | input | 1 | Firmware write strobe |
| fw_rd_i | input | 1 | Firmware read strobe |
| fw_addr_i | input | 16 | Firmware byte address |
| fw_wdata_i | input | 32 | Firmware write data |
| fw_rdata_o | output | 32 | Firmware read data, one cycle after the strobe |

## Verification
The bench reads a grant in the same cycle the arbiter hands it over. A design that granted combinationally, or that delayed the grant by an extra cycle, returns a different word there. Both agents request in the same cycle to check priority. A reversed priority shows the host bit in the grant register. A withdrawal by a pending agent must leave the holder in place, and a stray release from an uninvolved agent must leave the lock untouched; a design that cleared the owner on any grant write would free the lock in both cases. The bench also covers a holder that requests its own lock again, data that carries only the other agent's bit, and misaligned and out-of-range addresses. Each of these catches designs that act on the wrong bit or decode too loosely.

// File: rtl/sema_pkg.sv
package sema_pkg;
   // agent slots inside every per-lock pending/owner vector
   localparam int AG_FW      = 0;
   localparam int AG_HOST    = 1;
   localparam int NUM_AGENTS = 2;

   typedef logic [NUM_AGENTS-1:0] agent_vec_t;
endpackage

// File: rtl/sema_decode.sv
module sema_decode #(
   parameter int ADDR_W    = 16,
   parameter int NUM_LOCKS = 8,
   parameter int REQ_BASE  = 'h2C,
   parameter int GNT_BASE  = 'h4C,
   parameter int STRIDE    = 4,
   parameter int IDX_W     = $clog2(NUM_LOCKS)
) (
   input  logic [ADDR_W-1:0] addr_i,
   output logic              req_hit_o,
   output logic              gnt_hit_o,
   output logic [IDX_W-1:0]  idx_o
);
   localparam int ALIGN_W = $clog2(STRIDE);
   localparam logic [ADDR_W-1:0] REQ_B = ADDR_W'(REQ_BASE);
   localparam logic [ADDR_W-1:0] GNT_B = ADDR_W'(GNT_BASE);
   localparam logic [ADDR_W-1:0] SPAN  = ADDR_W'(NUM_LOCKS * STRIDE);

   logic [ADDR_W-1:0] req_off, gnt_off;

   assign req_off = addr_i - REQ_B;
   assign gnt_off = addr_i - GNT_B;

   assign req_hit_o = (addr_i >= REQ_B) && (req_off < SPAN) &&
                      (req_off[ALIGN_W-1:0] == '0);
   assign gnt_hit_o = (addr_i >= GNT_B) && (gnt_off < SPAN) &&
                      (gnt_off[ALIGN_W-1:0] == '0);

   always_comb begin
      if (req_hit_o)      idx_o = req_off[ALIGN_W +: IDX_W];
      else if (gnt_hit_o) idx_o = gnt_off[ALIGN_W +: IDX_W];
      else                idx_o = '0;
   end
endmodule

// File: rtl/sema_port.sv
module sema_port
   import sema_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int DATA_W    = 32,
   parameter int NUM_LOCKS = 8,
   parameter int REQ_BASE  = 'h2C,
   parameter int GNT_BASE  = 'h4C,
   parameter int STRIDE    = 4,
   parameter int MY_BIT    = 12,
   parameter int FW_BIT    = 0,
   parameter int HOST_BIT  = 12
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_i,
   input  logic                  rd_i,
   input  logic [ADDR_W-1:0]     addr_i,
   input  logic [DATA_W-1:0]     wdata_i,
   input  agent_vec_t [NUM_LOCKS-1:0] req_i,
   input  agent_vec_t [NUM_LOCKS-1:0] own_i,
   output logic [NUM_LOCKS-1:0]  set_o,
   output logic [NUM_LOCKS-1:0]  rel_o,
   output logic [DATA_W-1:0]     rdata_o
);
   localparam int IDX_W = $clog2(NUM_LOCKS);

   logic             req_hit, gnt_hit;
   logic [IDX_W-1:0] idx;
   logic             my_bit;
   logic             wdata_unused;
   logic [DATA_W-1:0] rd_word;

   sema_decode #(
      .ADDR_W(ADDR_W), .NUM_LOCKS(NUM_LOCKS), .REQ_BASE(REQ_BASE),
      .GNT_BASE(GNT_BASE), .STRIDE(STRIDE), .IDX_W(IDX_W)
   ) i_dec (
      .addr_i(addr_i), .req_hit_o(req_hit), .gnt_hit_o(gnt_hit), .idx_o(idx)
   );

   // only this agent's own bit carries meaning in write data
   assign my_bit       = wdata_i[MY_BIT];
   assign wdata_unused = ^wdata_i;

   always_comb begin
      for (int i = 0; i < NUM_LOCKS; i++) begin
         set_o[i] = wr_i && my_bit && req_hit && (idx == IDX_W'(i));
         rel_o[i] = wr_i && my_bit && gnt_hit && (idx == IDX_W'(i));
      end
   end

   function automatic logic [DATA_W-1:0] to_word(input agent_vec_t v);
      logic [DATA_W-1:0] w;
      w           = '0;
      w[FW_BIT]   = v[AG_FW];
      w[HOST_BIT] = v[AG_HOST];
      return w;
   endfunction

   always_comb begin
      if (req_hit)      rd_word = to_word(req_i[idx]);
      else if (gnt_hit) rd_word = to_word(own_i[idx]);
      else              rd_word = '0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)    rdata_o <= '0;
      else if (rd_i) rdata_o <= rd_word;
   end

   p_unmapped_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_i && !req_hit && !gnt_hit) |=> (rdata_o == '0));

   p_rdata_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_i |=> $stable(rdata_o));
endmodule

// File: rtl/sema_lock.sv
module sema_lock
   import sema_pkg::*;
#(
   parameter bit FW_FIRST = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  agent_vec_t set_i,
   input  agent_vec_t rel_i,
   output agent_vec_t req_o,
   output agent_vec_t own_o
);
   agent_vec_t req_q, own_q;
   agent_vec_t win, own_a, req_a, own_n, req_n;

   // arbitration on the registered state; the generate picks the priority order
   if (FW_FIRST) begin : g_fw_first
      always_comb begin
         win = '0;
         if (own_q == '0) begin
            if (req_q[AG_FW])        win[AG_FW]   = 1'b1;
            else if (req_q[AG_HOST]) win[AG_HOST] = 1'b1;
         end
      end
      p_fw_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
         (own_q == '0 && req_q[AG_FW] && !rel_i[AG_FW]) |=> own_q[AG_FW]);
   end else begin : g_host_first
      always_comb begin
         win = '0;
         if (own_q == '0) begin
            if (req_q[AG_HOST])    win[AG_HOST] = 1'b1;
            else if (req_q[AG_FW]) win[AG_FW]   = 1'b1;
         end
      end
   end

   always_comb begin
      own_a = (own_q == '0) ? win : own_q;
      req_a = req_q & ~win;
      // release / withdraw applies after this cycle's hand-over
      own_n = own_a & ~rel_i;
      req_n = (req_a & ~rel_i) | (set_i & ~own_a);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         req_q <= '0;
         own_q <= '0;
      end else begin
         req_q <= req_n;
         own_q <= own_n;
      end
   end

   assign req_o = req_q;
   assign own_o = own_q;

   p_single_owner_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(own_q));

   p_owner_not_pending_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (own_q & req_q) == '0);

   p_free_granted_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (own_q == '0 && req_q != '0 && rel_i == '0) |=> (own_q != '0));

   p_holder_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (own_q != '0 && (own_q & rel_i) == '0) |=> (own_q == $past(own_q)));

   p_release_frees_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ((own_q & rel_i) != '0) |=> (own_q == '0));
endmodule

// File: rtl/hw_sema_bank.sv
module hw_sema_bank
   import sema_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int DATA_W    = 32,
   parameter int NUM_LOCKS = 8,
   parameter int REQ_BASE  = 'h2C,
   parameter int GNT_BASE  = 'h4C,
   parameter int STRIDE    = 4,
   parameter int HOST_BIT  = 12,
   parameter int FW_BIT    = 0,
   parameter bit FW_FIRST  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_wr_i,
   input  logic              host_rd_i,
   input  logic [ADDR_W-1:0] host_addr_i,
   input  logic [DATA_W-1:0] host_wdata_i,
   output logic [DATA_W-1:0] host_rdata_o,
   input  logic              fw_wr_i,
   input  logic              fw_rd_i,
   input  logic [ADDR_W-1:0] fw_addr_i,
   input  logic [DATA_W-1:0] fw_wdata_i,
   output logic [DATA_W-1:0] fw_rdata_o
);
   localparam int SPAN = NUM_LOCKS * STRIDE;

   // elaboration-time parameter checks
   if (NUM_LOCKS < 2) begin : g_chk_locks
      $error("NUM_LOCKS must be at least 2");
   end
   if (STRIDE < 2 || (STRIDE & (STRIDE - 1)) != 0) begin : g_chk_stride
      $error("STRIDE must be a power of two of at least 2");
   end
   if (HOST_BIT == FW_BIT || HOST_BIT >= DATA_W || FW_BIT >= DATA_W) begin : g_chk_bits
      $error("agent bits must be distinct and inside the data word");
   end
   if (REQ_BASE + SPAN > GNT_BASE || GNT_BASE + SPAN > (1 << ADDR_W)) begin : g_chk_map
      $error("request and grant windows overlap or exceed the address space");
   end

   logic       [NUM_AGENTS-1:0]             wr_a, rd_a;
   logic       [NUM_AGENTS-1:0][ADDR_W-1:0] addr_a;
   logic       [NUM_AGENTS-1:0][DATA_W-1:0] wdata_a, rdata_a;
   logic       [NUM_AGENTS-1:0][NUM_LOCKS-1:0] set_a, rel_a;
   agent_vec_t [NUM_LOCKS-1:0]              lk_req, lk_own;

   assign wr_a[AG_FW]      = fw_wr_i;
   assign rd_a[AG_FW]      = fw_rd_i;
   assign addr_a[AG_FW]    = fw_addr_i;
   assign wdata_a[AG_FW]   = fw_wdata_i;
   assign wr_a[AG_HOST]    = host_wr_i;
   assign rd_a[AG_HOST]    = host_rd_i;
   assign addr_a[AG_HOST]  = host_addr_i;
   assign wdata_a[AG_HOST] = host_wdata_i;
   assign fw_rdata_o       = rdata_a[AG_FW];
   assign host_rdata_o     = rdata_a[AG_HOST];

   for (genvar a = 0; a < NUM_AGENTS; a++) begin : g_port
      sema_port #(
         .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_LOCKS(NUM_LOCKS),
         .REQ_BASE(REQ_BASE), .GNT_BASE(GNT_BASE), .STRIDE(STRIDE),
         .MY_BIT((a == AG_HOST) ? HOST_BIT : FW_BIT),
         .FW_BIT(FW_BIT), .HOST_BIT(HOST_BIT)
      ) i_port (
         .clk(clk), .rst_n(rst_n),
         .wr_i(wr_a[a]), .rd_i(rd_a[a]), .addr_i(addr_a[a]),
         .wdata_i(wdata_a[a]),
         .req_i(lk_req), .own_i(lk_own),
         .set_o(set_a[a]), .rel_o(rel_a[a]), .rdata_o(rdata_a[a])
      );
   end

   for (genvar n = 0; n < NUM_LOCKS; n++) begin : g_lock
      agent_vec_t set_n, rel_n;
      for (genvar a = 0; a < NUM_AGENTS; a++) begin : g_gather
         assign set_n[a] = set_a[a][n];
         assign rel_n[a] = rel_a[a][n];
      end
      sema_lock #(.FW_FIRST(FW_FIRST)) i_lock (
         .clk(clk), .rst_n(rst_n),
         .set_i(set_n), .rel_i(rel_n),
         .req_o(lk_req[n]), .own_o(lk_own[n])
      );
   end
endmodule

// File: tb/test_hw_sema_bank.sv
module test_hw_sema_bank;
   localparam int H = 1;
   localparam int F = 0;
   localparam logic [31:0] HB = 32'h0000_1000;
   localparam logic [31:0] FB = 32'h0000_0001;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_wr_i = 0, host_rd_i = 0, fw_wr_i = 0, fw_rd_i = 0;
   logic [15:0] host_addr_i = '0, fw_addr_i = '0;
   logic [31:0] host_wdata_i = '0, fw_wdata_i = '0;
   logic [31:0] host_rdata_o, fw_rdata_o;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   hw_sema_bank i_hw_sema_bank (
      .clk(clk), .rst_n(rst_n),
      .host_wr_i(host_wr_i), .host_rd_i(host_rd_i), .host_addr_i(host_addr_i),
      .host_wdata_i(host_wdata_i), .host_rdata_o(host_rdata_o),
      .fw_wr_i(fw_wr_i), .fw_rd_i(fw_rd_i), .fw_addr_i(fw_addr_i),
      .fw_wdata_i(fw_wdata_i), .fw_rdata_o(fw_rdata_o)
   );

   function automatic logic [15:0] ra(input int n);
      return 16'(16'h2C + 4 * n);
   endfunction
   function automatic logic [15:0] ga(input int n);
      return 16'(16'h4C + 4 * n);
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   // all tasks start and end at a falling edge
   task automatic wr(input int ag, input logic [15:0] a, input logic [31:0] d, input bit settle);
      if (ag == H) begin host_wr_i = 1; host_addr_i = a; host_wdata_i = d; end
      else         begin fw_wr_i = 1;   fw_addr_i = a;   fw_wdata_i = d;   end
      @(negedge clk);
      host_wr_i = 0; fw_wr_i = 0;
      if (settle) @(negedge clk);
   endtask

   task automatic wr_both(input logic [15:0] ah, input logic [31:0] dh,
                          input logic [15:0] af, input logic [31:0] df);
      host_wr_i = 1; host_addr_i = ah; host_wdata_i = dh;
      fw_wr_i = 1;   fw_addr_i = af;   fw_wdata_i = df;
      @(negedge clk);
      host_wr_i = 0; fw_wr_i = 0;
      @(negedge clk);
   endtask

   task automatic rd_chk(input int ag, input logic [15:0] a, input logic [31:0] exp, input string tag);
      logic [31:0] v;
      if (ag == H) begin host_rd_i = 1; host_addr_i = a; end
      else         begin fw_rd_i = 1;   fw_addr_i = a;   end
      @(negedge clk);
      host_rd_i = 0; fw_rd_i = 0;
      v = (ag == H) ? host_rdata_o : fw_rdata_o;
      chk(tag, v, exp);
   endtask

   task automatic t_reset;
      for (int n = 0; n < 8; n++) begin
         rd_chk(H, ra(n), 0, "R1 request after reset");
         rd_chk(H, ga(n), 0, "R1 grant after reset");
      end
      rd_chk(F, ga(4), 0, "R1 firmware view after reset");
   endtask

   task automatic t_basic_grant;
      wr(H, ra(0), HB, 0);
      rd_chk(H, ga(0), 0,  "R12 read in grant cycle shows old state");
      rd_chk(H, ga(0), HB, "R5 host granted free lock");
      rd_chk(H, ra(0), 0,  "R5 winner pending bit cleared");
      rd_chk(F, ga(0), HB, "R5 grant seen from firmware port");
   endtask

   task automatic t_wait_cancel_release;
      wr(F, ra(0), FB, 1);
      rd_chk(F, ra(0), FB, "R4 firmware pending while host holds");
      rd_chk(F, ga(0), HB, "R7 holder keeps lock");
      wr(F, ga(0), FB, 1);
      rd_chk(F, ra(0), 0,  "R8 pending request withdrawn");
      rd_chk(H, ga(0), HB, "R8 owner unchanged by withdraw");
      wr(F, ra(0), FB, 1);
      wr(H, ga(0), HB, 0);
      rd_chk(H, ga(0), 0,  "R7 lock free right after release");
      rd_chk(F, ga(0), FB, "R7 pending firmware granted next cycle");
      wr(F, ga(0), FB, 1);
      rd_chk(H, ga(0), 0,  "R7 firmware release frees lock");
   endtask

   task automatic t_priority;
      wr_both(ra(2), HB, ra(2), FB);
      rd_chk(H, ga(2), FB, "R6 firmware wins tie");
      rd_chk(H, ra(2), HB, "R6 host stays pending");
      rd_chk(H, ga(0), 0,  "R11 other lock untouched");
      wr(F, ga(2), FB, 1);
      rd_chk(H, ga(2), HB, "R6 host granted after firmware release");
      wr(H, ga(2), HB, 1);
      rd_chk(H, ga(2), 0,  "R7 host release");
   endtask

   task automatic t_stray_and_rerequest;
      wr(H, ra(3), HB, 1);
      wr(F, ga(3), FB, 1);
      rd_chk(H, ga(3), HB, "R9 stray release keeps owner");
      rd_chk(H, ra(3), 0,  "R9 stray release adds nothing");
      wr(H, ga(5), HB, 1);
      rd_chk(H, ga(5), 0,  "R9 release of free lock");
      rd_chk(H, ra(5), 0,  "R9 release of free lock pending");
      wr(H, ra(3), HB, 1);
      rd_chk(H, ra(3), 0,  "R10 holder request ignored");
      wr(H, ga(3), HB, 1);
      rd_chk(H, ga(3), 0,  "R10 no re-grant after release");
   endtask

   task automatic t_agent_bits;
      wr(H, ra(4), FB, 1);
      rd_chk(H, ra(4), 0,  "R3 host cannot set firmware bit");
      rd_chk(H, ga(4), 0,  "R3 no grant from foreign bit");
      wr(F, ra(4), HB, 1);
      rd_chk(F, ra(4), 0,  "R3 firmware cannot set host bit");
      wr(H, ra(4), 32'hFFFF_FFFF, 1);
      rd_chk(H, ga(4), HB, "R3 only own bit acts");
      wr(H, ga(4), 32'hFFFF_FFFF, 1);
      rd_chk(H, ga(4), 0,  "R3 release with extra bits");
   endtask

   task automatic t_address_map;
      wr(H, 16'h006C, HB, 1);
      wr(H, 16'h002E, HB, 1);
      wr(H, 16'h004A, HB, 1);
      wr(H, 16'h0028, HB, 1);
      rd_chk(H, ga(7), 0, "R2 out-of-range write ignored");
      rd_chk(H, ra(7), 0, "R2 out-of-range write ignored pending");
      rd_chk(H, ga(0), 0, "R2 misaligned write ignored");
      rd_chk(H, ra(0), 0, "R2 misaligned write ignored pending");
      wr(H, 16'h0048, HB, 1);
      rd_chk(H, 16'h0068, HB, "R2 last lock at top of map");
      rd_chk(H, 16'h006C, 0,  "R2 unmapped read zero");
      rd_chk(H, 16'h002E, 0,  "R2 misaligned read zero");
      wr(F, ra(6), FB, 1);
      rd_chk(F, ga(6), FB, "R11 neighbour lock independent");
      rd_chk(F, ga(7), HB, "R11 lock 7 unaffected");
      wr(H, ga(7), HB, 1);
      wr(F, ga(6), FB, 1);
   endtask

   task automatic finish_run;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_basic_grant;
      t_wait_cancel_release;
      t_priority;
      t_stray_and_rerequest;
      t_agent_bits;
      t_address_map;
      finish_run;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run;
   end
endmodule